// File: doc/BRIEF.md
# Pause-Width Reader Frame Encoder

This block sends a reader-to-tag command of up to 32 bits by switching a single carrier-enable line. Every bit cell opens with a short, fixed carrier-off pause and then holds the carrier on. The value of the bit is carried by how long the carrier stays on: a long on-time codes a one and a short on-time codes a zero. After the last data bit, one more pause with no on-time after it closes the frame.

All durations are counted in ticks of an external one-microsecond strobe and are set by parameters, so a system can trim them for latency. The block also keeps a free-running count of ticks since reset. When the closing pause ends, it latches that count as the end-of-frame timestamp, so that a receive path can time its turnaround from the end of the frame. A host loads a command word and a bit count and pulses start. It then waits for the one-clock done pulse.

Top module: `pause_frame_tx`

## Requirements
- R1: After reset, carrierOn is 1, busy is 0, done is 0 and endStamp is 0. While idle, carrierOn stays 1.
- R2: Each bit cell begins with carrierOn at 0 for exactly PAUSE_TICKS tick strobes (default 20), after which carrierOn returns to 1. The first pause starts on the clock edge that accepts start.
- R3: A one bit holds carrierOn at 1 for exactly ONE_TICKS tick strobes (default 80), giving a 100-tick cell.
- R4: A zero bit holds carrierOn at 1 for exactly ZERO_TICKS tick strobes (default 40), giving a 60-tick cell.
- R5: Bits are sent least significant first, from cmdWord bit 0 upward. The number of bits sent equals the bitCount sampled with start.
- R6: After the last bit there is one closing pause of PAUSE_TICKS tick strobes. On the clock edge where it ends, carrierOn returns to 1, busy falls and done goes high for exactly one clock.
- R7: endStamp takes the number of tick strobes seen since reset, counting the one that ended the closing pause. It changes at no other time.
- R8: A start with bitCount equal to 0 is ignored: busy stays 0 and carrierOn stays 1.
- R9: A start pulse while busy is ignored. The frame in progress continues unchanged with its original word and length.
- R10: A bitCount above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickUs | input | 1 | One-clock strobe per microsecond |
| start | input | 1 | Start request, sampled while idle |
| cmdWord | input | 32 | Command bits, bit 0 sent first |
| bitCount | input | 6 | Number of bits to send (0 ignored, above 32 clamped) |
| carrierOn | output | 1 | Carrier enable, 0 during pauses |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse when the closing pause ends |
| endStamp | output | 32 | Tick count latched at frame end |

## Verification
The bench drives frames with mixed bits (0xA5), a single one, a single zero, a full 32-bit word and a 40-bit request. These tell apart long from short on-times, bit order, off-by-one errors in the bit count at both ends of the range, and clamping. A monitor turns the carrier line back into pause and on-time lengths in ticks, and also checks the closing pause, the done pulse and the timestamp against its own tick count. A zero-length start and a second start sent during a frame show whether inputs that should be ignored change the line or the decoded frame.

// File: rtl/pft_pkg.sv
package pft_pkg;
  typedef struct packed {
    logic load;       // capture word and length
    logic loadPause;  // arm duration counter with pause length
    logic loadOn;     // arm duration counter with on-time of current bit
    logic shift;      // retire current bit
    logic stamp;      // latch end-of-frame timestamp
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_ON    = 2'd2,
    ST_CLOSE = 2'd3
  } txState_t;
endpackage

// File: rtl/pft_datapath.sv
module pft_datapath #(
  parameter int MAX_BITS    = 32,
  parameter int BCNT_W      = 6,
  parameter int TS_W        = 32,
  parameter int PAUSE_TICKS = 20,
  parameter int ONE_TICKS   = 80,
  parameter int ZERO_TICKS  = 40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tickUs,
  input  logic [MAX_BITS-1:0]     cmdWord,
  input  logic [BCNT_W-1:0]       bitCount,
  input  pft_pkg::ctlStrobe_t     stb,
  output logic                    phaseEnd,
  output logic                    lastBit,
  output logic                    countZero,
  output logic [TS_W-1:0]         endStamp
);
  localparam int CNT_W   = $clog2(MAX_BITS + 1);
  localparam int MAX_A   = (PAUSE_TICKS > ONE_TICKS) ? PAUSE_TICKS : ONE_TICKS;
  localparam int MAX_DUR = (MAX_A > ZERO_TICKS) ? MAX_A : ZERO_TICKS;
  localparam int DUR_W   = $clog2(MAX_DUR + 1);

  logic [MAX_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]    bitsLeft;
  logic [CNT_W-1:0]    clampedCnt;
  logic [DUR_W-1:0]    durCnt;
  logic [TS_W-1:0]     tickCount;

  always_comb begin
    if (bitCount > BCNT_W'(MAX_BITS)) clampedCnt = CNT_W'(MAX_BITS);
    else                              clampedCnt = CNT_W'(bitCount);
  end

  assign countZero = (clampedCnt == '0);
  assign lastBit   = (bitsLeft == CNT_W'(1));
  assign phaseEnd  = tickUs && (durCnt == DUR_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitsLeft <= '0;
    end else if (stb.load) begin
      shiftReg <= cmdWord;
      bitsLeft <= clampedCnt;
    end else if (stb.shift) begin
      shiftReg <= shiftReg >> 1;
      bitsLeft <= bitsLeft - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      durCnt <= '0;
    end else if (stb.loadPause) begin
      durCnt <= DUR_W'(PAUSE_TICKS);
    end else if (stb.loadOn) begin
      durCnt <= shiftReg[0] ? DUR_W'(ONE_TICKS) : DUR_W'(ZERO_TICKS);
    end else if (tickUs && durCnt != '0) begin
      durCnt <= durCnt - DUR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCount <= '0;
      endStamp  <= '0;
    end else begin
      if (tickUs) tickCount <= tickCount + TS_W'(1);
      if (stb.stamp) endStamp <= tickCount + TS_W'(1);
    end
  end
endmodule

// File: rtl/pft_control.sv
module pft_control (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                phaseEnd,
  input  logic                lastBit,
  input  logic                countZero,
  output pft_pkg::ctlStrobe_t stb,
  output logic                carrierOn,
  output logic                busy,
  output logic                done
);
  import pft_pkg::*;

  txState_t state, nextState;
  logic     doneQ;

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      ST_IDLE: if (start && !countZero) begin
        stb.load      = 1'b1;
        stb.loadPause = 1'b1;
        nextState     = ST_PAUSE;
      end
      ST_PAUSE: if (phaseEnd) begin
        stb.loadOn = 1'b1;
        nextState  = ST_ON;
      end
      ST_ON: if (phaseEnd) begin
        stb.shift     = 1'b1;
        stb.loadPause = 1'b1;
        nextState     = lastBit ? ST_CLOSE : ST_PAUSE;
      end
      ST_CLOSE: if (phaseEnd) begin
        stb.stamp = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= nextState;
      doneQ <= stb.stamp;
    end
  end

  assign carrierOn = !(state == ST_PAUSE || state == ST_CLOSE);
  assign busy      = (state != ST_IDLE);
  assign done      = doneQ;
endmodule

// File: rtl/pause_frame_tx.sv
module pause_frame_tx #(
  parameter int MAX_BITS    = 32,
  parameter int BCNT_W      = 6,
  parameter int TS_W        = 32,
  parameter int PAUSE_TICKS = 20,
  parameter int ONE_TICKS   = 80,
  parameter int ZERO_TICKS  = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickUs,
  input  logic                start,
  input  logic [MAX_BITS-1:0] cmdWord,
  input  logic [BCNT_W-1:0]   bitCount,
  output logic                carrierOn,
  output logic                busy,
  output logic                done,
  output logic [TS_W-1:0]     endStamp
);
  pft_pkg::ctlStrobe_t stb;
  logic phaseEnd, lastBit, countZero;

  pft_control u_ctl (
    .clk(clk), .rstN(rstN), .start(start),
    .phaseEnd(phaseEnd), .lastBit(lastBit), .countZero(countZero),
    .stb(stb), .carrierOn(carrierOn), .busy(busy), .done(done)
  );

  pft_datapath #(
    .MAX_BITS(MAX_BITS), .BCNT_W(BCNT_W), .TS_W(TS_W),
    .PAUSE_TICKS(PAUSE_TICKS), .ONE_TICKS(ONE_TICKS), .ZERO_TICKS(ZERO_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickUs(tickUs),
    .cmdWord(cmdWord), .bitCount(bitCount), .stb(stb),
    .phaseEnd(phaseEnd), .lastBit(lastBit), .countZero(countZero),
    .endStamp(endStamp)
  );
endmodule

// File: rtl/pause_frame_tx_chk.sv
module pause_frame_tx_chk #(
  parameter int BCNT_W = 6,
  parameter int TS_W   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickUs,
  input logic              start,
  input logic [BCNT_W-1:0] bitCount,
  input logic              carrierOn,
  input logic              busy,
  input logic              done,
  input logic [TS_W-1:0]   endStamp
);
  AST_IDLE_CARRIER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> carrierOn); // R1

  AST_CARRIER_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carrierOn) |-> $past(tickUs)); // R2

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!busy && $past(busy) && carrierOn)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_STAMP_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(endStamp) |-> done); // R7

  AST_ZERO_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && bitCount == '0) |=> (!busy && carrierOn)); // R8
endmodule

bind pause_frame_tx pause_frame_tx_chk #(.BCNT_W(BCNT_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickUs(tickUs), .start(start), .bitCount(bitCount),
  .carrierOn(carrierOn), .busy(busy), .done(done), .endStamp(endStamp)
);

// File: tb/pause_frame_tx_tb.sv
`timescale 1ns/1ps
module pause_frame_tx_tb;
  localparam int PAUSE_T = 20;
  localparam int ONE_T   = 80;
  localparam int ZERO_T  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickUs = 1'b0;
  logic start = 1'b0;
  logic [31:0] cmdWord = '0;
  logic [5:0]  bitCount = '0;
  logic carrierOn, busy, done;
  logic [31:0] endStamp;

  always #2.5 clk = ~clk;  // 200 MHz

  pause_frame_tx u_dut (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .start(start),
    .cmdWord(cmdWord), .bitCount(bitCount),
    .carrierOn(carrierOn), .busy(busy), .done(done), .endStamp(endStamp)
  );

  // tick strobe: high every other clock
  always @(posedge clk) tickUs <= ~tickUs;

  int vectors = 0;
  int miscompares = 0;
  logic [37:0] expQ[$];   // {count[5:0], data[31:0]}

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  int benchTicks = 0;
  int lowTicks = 0, highTicks = 0, gotN = 0;
  logic [31:0] gotData = '0;
  logic [37:0] curExp = '0;
  logic inFrame = 1'b0, prevC = 1'b1, doneLast = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (doneLast) check(!done, "R6 done width", done, 0);
      doneLast = done;
      if (carrierOn != prevC) begin
        if (!carrierOn) begin
          if (!inFrame) begin
            inFrame = 1'b1; gotN = 0; gotData = '0;
            if (expQ.size() > 0) curExp = expQ.pop_front();
            else check(1'b0, "R8/R9 unexpected frame", 1, 0);
          end else begin
            if (gotN < 32) begin
              if (curExp[gotN]) check(highTicks == ONE_T, "R3 one on-time", highTicks, ONE_T);
              else              check(highTicks == ZERO_T, "R4 zero on-time", highTicks, ZERO_T);
              gotData[gotN] = (highTicks == ONE_T);
            end
            gotN++;
          end
          lowTicks = 0;
        end else begin
          highTicks = 0;
          if (done) begin
            check(lowTicks == PAUSE_T, "R6 closing pause", lowTicks, PAUSE_T);
            check(!busy, "R6 busy drops with done", busy, 0);
            check(gotN == int'(curExp[37:32]), "R5 bit count", gotN, curExp[37:32]);
            check(gotData == curExp[31:0], "R5 data LSB first", gotData, curExp[31:0]);
            check(endStamp == benchTicks, "R7 end stamp", endStamp, benchTicks);
            inFrame = 1'b0;
          end else begin
            check(lowTicks == PAUSE_T, "R2 bit pause", lowTicks, PAUSE_T);
          end
        end
        prevC = carrierOn;
      end else if (done) begin
        check(1'b0, "R6 done without carrier rise", 1, 0);
      end
      if (tickUs) begin
        benchTicks++;
        if (!carrierOn) lowTicks++;
        else if (inFrame) highTicks++;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic sendFrame(input logic [31:0] w, input int n, input bit poke);
    int cn = (n > 32) ? 32 : n;
    logic [31:0] m = (cn == 32) ? 32'hFFFF_FFFF : ((32'h1 << cn) - 32'h1);
    expQ.push_back({6'(cn), w & m});
    @(negedge clk);
    cmdWord = w; bitCount = 6'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      cmdWord = ~w; bitCount = 6'd5; start = 1'b1;   // R9: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(carrierOn == 1'b1, "R1 reset carrier", carrierOn, 1);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    check(endStamp == 0, "R1 reset stamp", endStamp, 0);

    sendFrame(32'h0000_00A5, 8, 0);
    sendFrame(32'h0000_0001, 1, 0);
    sendFrame(32'hFFFF_FFFE, 1, 0);
    sendFrame(32'hDEAD_BEEF, 32, 0);
    sendFrame(32'h0000_FFFF, 40, 0);   // R10 clamp to 32
    sendFrame(32'h0000_003C, 6, 1);    // R9 start while busy

    // R8: zero-length start ignored
    @(negedge clk);
    cmdWord = 32'hFFFF_FFFF; bitCount = 6'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) begin
      @(negedge clk);
      check(!busy, "R8 zero count busy", busy, 0);
      check(carrierOn, "R8 zero count carrier", carrierOn, 1);
    end
    check(expQ.size() == 0 && !inFrame, "R5 all frames seen", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule